// File: doc/BRIEF.md
# CAN Controller Operating-Mode and Soft-Reset Sequencer

This block owns the operating mode of a CAN controller. The four modes are disabled, normal, frozen and soft reset. Software writes a small control word in the bus clock domain. The word holds a module-disable bit, a freeze-enable bit, a halt bit and a soft-reset bit. The block turns that word into a stop request and a reset request for the protocol engine, which runs on its own clock.

Both requests cross into the protocol domain through two-flop synchronizers, and both are acknowledged back the same way. The soft reset uses a four-phase request/acknowledge exchange. The soft-reset bit reads back as set for the whole exchange, so software can poll it to learn when the reset has finished. A system-level soft-reset pulse starts the same sequence.

While the protocol engine is stopped or being reset, the block holds the engine's run enable low and forces the transmit pin to the recessive level. The run enable being low means the engine neither sends nor accepts frames. The block also reports freeze acknowledge and not-ready status. Message-buffer storage is not reset by this block.

Top module: `can_mode_seq`

## Requirements
- R1: After the asynchronous hard reset, cfg_rdata reads 4'b0001 (bit0 = module disable set, all other bits clear), frz_ack_o is 0, not_rdy_o is 1, proto_run_o is 0 and tx_pin is 1.
- R2: When no soft reset is pending, a write (cfg_we high) of a word with bit3 clear loads bit0 (disable), bit1 (freeze enable) and bit2 (halt) into cfg_rdata, readable from the bus cycle after the write.
- R3: frz_ack_o rises only after the protocol side has acknowledged the stop, so it is 0 in the cycle after the write that requests freeze. It is set only while freeze is latched and bit0 is clear; with bit0 set, freeze enable plus halt gives frz_ack_o = 0.
- R4: While the protocol engine is stopped (disabled, frozen or in soft reset), proto_run_o is 0 and tx_pin is 1 (recessive) whatever tx_in is; in normal mode tx_pin follows tx_in.
- R5: not_rdy_o is 1 while a stop is requested, while the protocol side still acknowledges a stop, or while a soft reset is pending. It goes to 0 after freeze is left and the acknowledge has dropped.
- R6: Writing bit3 = 1, or pulsing sys_soft_rst, sets cfg_rdata bit3 from the next bus cycle. Bit3 stays set until the four-phase exchange ends (request up, acknowledge up, request down, acknowledge down), then reads 0.
- R7: Starting a soft reset clears bit1 and bit2 and keeps bit0. Any other bits of a write carrying bit3 are not loaded.
- R8: During the exchange the protocol side raises proto_srst_o, and proto_run_o is 0 whenever proto_srst_o is 1.
- R9: While bit3 reads 1, writes and further soft-reset requests have no effect on cfg_rdata bits 0 to 2.
- R10: Freeze is entered when bit1 and bit2 are both set and bit0 is clear. Once entered, freeze is left only when bit1 and bit2 are both clear; clearing just one of them keeps frz_ack_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus (register) clock |
| clk_proto | input | 1 | Protocol engine clock |
| rst_n | input | 1 | Asynchronous hard reset, active low, both domains |
| sys_soft_rst | input | 1 | System-level soft-reset pulse, bus domain |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Write data: bit0 disable, bit1 freeze enable, bit2 halt, bit3 soft reset |
| cfg_rdata | output | 4 | Readback, same bit map; bit3 = soft reset pending |
| frz_ack_o | output | 1 | Freeze acknowledged |
| not_rdy_o | output | 1 | Controller not ready |
| proto_run_o | output | 1 | Run enable for protocol state machines (protocol domain) |
| proto_srst_o | output | 1 | Soft reset to protocol-domain logic |
| tx_in | input | 1 | Transmit bit from the protocol engine |
| tx_pin | output | 1 | Transmit pin, 1 = recessive |

## Verification
On every cycle the assertions check four things: the transmit pin is recessive whenever the engine is not running, and the engine never runs while its soft reset is applied. They also check that freeze acknowledge implies latched freeze bits and not-ready, and that the mode bits hold steady and start cleared while a soft reset is pending. Only the bench scenarios can show three more things: the cross-domain latencies, such as acknowledge arriving later than the request and the pending bit eventually clearing, the hysteresis when leaving freeze, and the full table of mode transitions with tx_in passing through in normal mode.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    localparam int CTRL_W = 4;
    localparam int B_DIS  = 0;
    localparam int B_FRZ  = 1;
    localparam int B_HALT = 2;
    localparam int B_SRST = 3;

    typedef struct packed {
        logic dis;
        logic frz;
        logic halt;
        logic frz_lat;
        logic stop;
        logic sreq;
        logic spend;
    } bus_st_t;

    typedef struct packed {
        logic stopped;
        logic srst;
        logic run;
    } proto_st_t;
endpackage

// File: rtl/can_mode_sync.sv
module can_mode_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/can_mode_bus_ctl.sv
module can_mode_bus_ctl
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_soft_rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              stop_ack_s,
    input  logic              srst_ack_s,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              frz_ack,
    output logic              not_rdy,
    output logic              stop_req,
    output logic              srst_req
);
    bus_st_t st_q, st_d;
    logic    start_srst;

    always_comb begin
        st_d       = st_q;
        start_srst = !st_q.spend && (sys_soft_rst || (cfg_we && cfg_wdata[B_SRST]));
        if (st_q.spend) begin
            // four-phase: drop request once acknowledged, finish once ack drops
            if (st_q.sreq && srst_ack_s)
                st_d.sreq = 1'b0;
            else if (!st_q.sreq && !srst_ack_s)
                st_d.spend = 1'b0;
        end else if (start_srst) begin
            st_d.sreq  = 1'b1;
            st_d.spend = 1'b1;
            st_d.frz   = 1'b0;
            st_d.halt  = 1'b0;
        end else if (cfg_we) begin
            st_d.dis  = cfg_wdata[B_DIS];
            st_d.frz  = cfg_wdata[B_FRZ];
            st_d.halt = cfg_wdata[B_HALT];
        end
        // freeze latch: enter on both bits, leave only when both are clear
        st_d.frz_lat = st_q.frz_lat ? (st_d.frz || st_d.halt)
                                    : (st_d.frz && st_d.halt && !st_d.dis);
        st_d.stop    = st_d.dis || st_d.frz_lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.dis     <= 1'b1;
            st_q.stop    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = {st_q.spend, st_q.halt, st_q.frz, st_q.dis};
    assign frz_ack   = st_q.frz_lat && !st_q.dis && stop_ack_s;
    assign not_rdy   = st_q.stop || stop_ack_s || st_q.spend;
    assign stop_req  = st_q.stop;
    assign srst_req  = st_q.sreq;
endmodule

// File: rtl/can_mode_proto_ctl.sv
module can_mode_proto_ctl
    import can_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic srst_req,
    input  logic tx_in,
    output logic stop_ack,
    output logic srst_ack,
    output logic run,
    output logic srst_o,
    output logic tx_pin
);
    logic      stop_s, srst_s;
    proto_st_t st_q, st_d;

    can_mode_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .d(stop_req), .q(stop_s)
    );
    can_mode_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_srst_sync (
        .clk(clk), .rst_n(rst_n), .d(srst_req), .q(srst_s)
    );

    always_comb begin
        st_d         = st_q;
        st_d.stopped = stop_s;
        st_d.srst    = srst_s;
        st_d.run     = !stop_s && !srst_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stopped <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stop_ack = st_q.stopped;
    assign srst_ack = st_q.srst;
    assign run      = st_q.run;
    assign srst_o   = st_q.srst;
    assign tx_pin   = st_q.run ? tx_in : 1'b1;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_bus,
    input  logic              clk_proto,
    input  logic              rst_n,
    input  logic              sys_soft_rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              frz_ack_o,
    output logic              not_rdy_o,
    output logic              proto_run_o,
    output logic              proto_srst_o,
    input  logic              tx_in,
    output logic              tx_pin
);
    logic stop_req, srst_req;
    logic stop_ack, srst_ack;
    logic stop_ack_s, srst_ack_s;

    can_mode_bus_ctl u_bus (
        .clk          (clk_bus),
        .rst_n        (rst_n),
        .sys_soft_rst (sys_soft_rst),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .stop_ack_s   (stop_ack_s),
        .srst_ack_s   (srst_ack_s),
        .cfg_rdata    (cfg_rdata),
        .frz_ack      (frz_ack_o),
        .not_rdy      (not_rdy_o),
        .stop_req     (stop_req),
        .srst_req     (srst_req)
    );

    can_mode_proto_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_proto (
        .clk      (clk_proto),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .srst_req (srst_req),
        .tx_in    (tx_in),
        .stop_ack (stop_ack),
        .srst_ack (srst_ack),
        .run      (proto_run_o),
        .srst_o   (proto_srst_o),
        .tx_pin   (tx_pin)
    );

    can_mode_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_ack_sync (
        .clk(clk_bus), .rst_n(rst_n), .d(stop_ack), .q(stop_ack_s)
    );
    can_mode_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_srst_ack_sync (
        .clk(clk_bus), .rst_n(rst_n), .d(srst_ack), .q(srst_ack_s)
    );
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic       clk_bus,
    input logic       clk_proto,
    input logic       rst_n,
    input logic [3:0] cfg_rdata,
    input logic       frz_ack_o,
    input logic       not_rdy_o,
    input logic       proto_run_o,
    input logic       proto_srst_o,
    input logic       tx_pin
);
    p_recessive_r4: assert property (@(posedge clk_proto) disable iff (!rst_n)
        !proto_run_o |-> tx_pin);

    p_srst_stops_r8: assert property (@(posedge clk_proto) disable iff (!rst_n)
        proto_srst_o |-> !proto_run_o);

    p_ack_not_ready_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        frz_ack_o |-> not_rdy_o);

    p_ack_needs_bits_r10: assert property (@(posedge clk_bus) disable iff (!rst_n)
        frz_ack_o |-> (cfg_rdata[1] || cfg_rdata[2]));

    p_pending_hold_r9: assert property (@(posedge clk_bus) disable iff (!rst_n)
        cfg_rdata[3] |=> $stable(cfg_rdata[2:0]));

    p_srst_clears_r7: assert property (@(posedge clk_bus) disable iff (!rst_n)
        $rose(cfg_rdata[3]) |-> (!cfg_rdata[1] && !cfg_rdata[2]));

    p_pending_not_ready_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        cfg_rdata[3] |-> not_rdy_o);
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk_bus      (clk_bus),
    .clk_proto    (clk_proto),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .frz_ack_o    (frz_ack_o),
    .not_rdy_o    (not_rdy_o),
    .proto_run_o  (proto_run_o),
    .proto_srst_o (proto_srst_o),
    .tx_pin       (tx_pin)
);

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;
    logic       clk_bus = 1'b0;
    logic       clk_proto = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_soft_rst = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [3:0] cfg_rdata;
    logic       frz_ack_o, not_rdy_o, proto_run_o, proto_srst_o;
    logic       tx_in = 1'b0;
    logic       tx_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk_bus = ~clk_bus;
    always #7 clk_proto = ~clk_proto;

    can_mode_seq u_can_mode_seq (
        .clk_bus(clk_bus), .clk_proto(clk_proto), .rst_n(rst_n),
        .sys_soft_rst(sys_soft_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .frz_ack_o(frz_ack_o), .not_rdy_o(not_rdy_o),
        .proto_run_o(proto_run_o), .proto_srst_o(proto_srst_o),
        .tx_in(tx_in), .tx_pin(tx_pin)
    );

    // {wdata[3:0], tx_in, exp rdata[3:0], exp frz_ack, exp not_rdy, exp tx_pin}
    localparam logic [11:0] VEC [11] = '{
        12'b0001_0_0001_0_1_1,  // disabled
        12'b0000_0_0000_0_0_0,  // normal, tx follows 0
        12'b0000_1_0000_0_0_1,  // normal, tx follows 1
        12'b0110_0_0110_1_1_1,  // freeze
        12'b0100_0_0100_1_1_1,  // halt only: still frozen
        12'b0000_0_0000_0_0_0,  // leave freeze
        12'b0111_0_0111_0_1_1,  // freeze bits with disable: no ack
        12'b0110_0_0110_1_1_1,  // clear disable: ack
        12'b0010_1_0010_1_1_1,  // freeze enable only: still frozen
        12'b0000_0_0000_0_0_0,  // leave freeze
        12'b0010_0_0010_0_0_0   // freeze enable only from normal: no freeze
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] w);
        @(negedge clk_bus);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk_bus);
        cfg_we    = 1'b0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk_bus);
    endtask

    task automatic wait_srst(output bit finished, output bit saw_srst, output bit overlap);
        finished = 1'b0;
        saw_srst = 1'b0;
        overlap  = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_bus);
            if (proto_srst_o) saw_srst = 1'b1;
            if (proto_srst_o && proto_run_o) overlap = 1'b1;
            if (!cfg_rdata[3]) begin
                finished = 1'b1;
                break;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_bus);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit fin, saw, ovl;
        repeat (3) @(negedge clk_bus);
        // R1: reset state
        chk("R1 rdata", {4'h0, cfg_rdata}, 8'h01);
        chk("R1 frz_ack", {7'h0, frz_ack_o}, 8'h0);
        chk("R1 not_rdy", {7'h0, not_rdy_o}, 8'h1);
        chk("R1 run", {7'h0, proto_run_o}, 8'h0);
        chk("R1 tx_pin", {7'h0, tx_pin}, 8'h1);
        rst_n = 1'b1;
        settle();
        chk("R1 settled rdata", {4'h0, cfg_rdata}, 8'h01);

        // table walk: R2 R3 R4 R5 R10
        foreach (VEC[i]) begin
            tx_in = VEC[i][7];
            wr(VEC[i][11:8]);
            chk("R2 write visible next cycle", {4'h0, cfg_rdata}, {4'h0, VEC[i][6:3]});
            settle();
            chk("R3/R10 frz_ack", {7'h0, frz_ack_o}, {7'h0, VEC[i][2]});
            chk("R5 not_rdy", {7'h0, not_rdy_o}, {7'h0, VEC[i][1]});
            chk("R4 tx_pin", {7'h0, tx_pin}, {7'h0, VEC[i][0]});
            chk("R4 run", {7'h0, proto_run_o}, {7'h0, !VEC[i][1]});
        end

        // R3/R5: acknowledge lags the freeze request
        wr(4'b0000);
        settle();
        wr(4'b0110);
        chk("R5 not_rdy right after freeze write", {7'h0, not_rdy_o}, 8'h1);
        chk("R3 no ack right after freeze write", {7'h0, frz_ack_o}, 8'h0);
        settle();
        chk("R3 ack after crossing", {7'h0, frz_ack_o}, 8'h1);

        // R6/R7: soft reset by write from freeze
        wr(4'b1110);
        chk("R6/R7 pending, bits cleared", {4'h0, cfg_rdata}, 8'h08);
        wr(4'b0001);
        chk("R9 write ignored while pending", {4'h0, cfg_rdata}, 8'h08);
        wait_srst(fin, saw, ovl);
        chk("R6 pending clears", {7'h0, fin}, 8'h1);
        chk("R8 proto reset seen", {7'h0, saw}, 8'h1);
        chk("R8 no run during reset", {7'h0, ovl}, 8'h0);
        chk("R6/R9 rdata after reset", {4'h0, cfg_rdata}, 8'h00);
        settle();
        chk("R5 ready after reset", {7'h0, not_rdy_o}, 8'h0);
        tx_in = 1'b0;
        #1;
        chk("R4 tx follows after reset", {7'h0, tx_pin}, 8'h0);

        // R7: system soft reset keeps disable
        wr(4'b0111);
        settle();
        @(negedge clk_bus);
        sys_soft_rst = 1'b1;
        @(negedge clk_bus);
        sys_soft_rst = 1'b0;
        chk("R6/R7 system reset keeps disable", {4'h0, cfg_rdata}, 8'h09);
        @(negedge clk_bus);
        sys_soft_rst = 1'b1;
        @(negedge clk_bus);
        sys_soft_rst = 1'b0;
        chk("R9 second request ignored", {4'h0, cfg_rdata}, 8'h09);
        wait_srst(fin, saw, ovl);
        chk("R6 system reset completes", {7'h0, fin}, 8'h1);
        chk("R7 rdata after system reset", {4'h0, cfg_rdata}, 8'h01);
        settle();
        chk("R4 disabled tx recessive", {7'h0, tx_pin}, 8'h1);

        finish_run();
    end
endmodule